// File: doc/BRIEF.md
# Programmable Single-Channel PWM Timer

This block generates one pulse-width-modulated output whose period and high time are counted in ticks of a prescaled clock. Software programs it through two 32-bit registers on a simple synchronous register port: a control word (run enable, hold bit and a power-of-two clock divider) and a count word (period length and high time, each 10 bits). The output has normal polarity only. It is high at the start of each period and low for the rest.

A hold bit lets software change the divider and both counts without the running waveform ever seeing a half-written combination. While hold is set, writes only update the programmed copies, which read back at once. After hold is cleared, the running channel takes all new settings together at the next period boundary. An idle channel takes them on the next clock. A channel whose programmed period or high count is zero cannot be started.

Top module: `pwm_timer`

## Requirements
- R1: After reset the output is low, and both registers (control at byte address 0x0, count at 0x4) read as zero. Any other address reads zero.
- R2: A read strobe returns data with the valid flag exactly one cycle later. The control word reads back all 32 bits as written, except for the refused run bit of R3. The count word holds the period in bits 25:16 and the high time in bits 9:0, and all its other bits read zero.
- R3: A control write that sets the run bit (bit 0) while the stored period or high count is zero stores the run bit as 0. The output then stays low.
- R4: Once running, each period lasts period*2^n clock cycles and the output is high for the first high*2^n of them. The first high cycle is the second cycle after the clock edge that took the enabling write.
- R5: The divider exponent n is twice the control field in bits 19:16 plus control bit 15.
- R6: When the high count is greater than or equal to the period count, the output stays high for the whole period.
- R7: While the hold bit (control bit 11) is set, writes to the count word or the divider fields do not change the running waveform. The registers read back the new values at once.
- R8: After hold is cleared on a running channel, the new period, high time and divider all take effect together at the next period boundary.
- R9: Settings written while the channel is not running take effect on the next clock, so a following enable uses them.
- R10: Clearing the run bit drives the output low in the cycle after the write edge and resets the counters. A later enable starts a fresh period.
- R11: A count write with a zero period or a zero high count leaves the settings of the running waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| pwm_o | output | 1 | PWM output, active high |

## Verification
Read data and its valid flag are checked in the cycle after the read strobe. A disable is checked in the first cycle after its write edge. An enable is expected to show one low cycle and then the high phase, so the expected waveform is queued starting at the cycle after the write edge. Settings changed under hold apply only at a period boundary, so the bench locks onto a rising edge of the output before queuing each expected stream. It times the hold-release write so that it cannot coincide with a boundary. Every queued item is compared against the output one cycle at a time, so a phase shift by a single cycle is reported.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int CNT_W    = 10;
    localparam int EXP_W    = 5;
    localparam int EXP_MAX  = 24;
    localparam int PRE_W    = EXP_MAX;
    localparam int DIVHI_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(4);

    localparam int B_RUN       = 0;
    localparam int B_HOLD      = 11;
    localparam int B_DIVLO     = 15;
    localparam int F_DIVHI_LSB = 16;
    localparam int F_PER_LSB   = 16;
    localparam int F_HIGH_LSB  = 0;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
    } tcfg_t;

    function automatic logic [EXP_W-1:0] ctrl_exp(input logic [REG_W-1:0] c);
        logic [EXP_W-1:0] n;
        n = {c[F_DIVHI_LSB +: DIVHI_W], c[B_DIVLO]};
        if (int'(n) > EXP_MAX) n = EXP_W'(EXP_MAX);
        return n;
    endfunction

    function automatic logic [REG_W-1:0] count_word(input logic [CNT_W-1:0] per,
                                                    input logic [CNT_W-1:0] hi);
        logic [REG_W-1:0] w;
        w = '0;
        w[F_PER_LSB +: CNT_W]  = per;
        w[F_HIGH_LSB +: CNT_W] = hi;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              rd_valid_o,
    output logic              run_o,
    output logic              hold_o,
    output tcfg_t             prog_o,
    output logic              upd_o
);

    logic [REG_W-1:0] ctrl_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] high_q;
    logic [REG_W-1:0] ctrl_wr;
    logic             sel_ctrl;
    logic             sel_cnt;

    assign sel_ctrl = (addr_i == OFS_CTRL);
    assign sel_cnt  = (addr_i == OFS_COUNT);

    // refuse to start with a prohibited count
    always_comb begin
        ctrl_wr = wr_data_i;
        if (ctrl_wr[B_RUN] && (per_q == '0 || high_q == '0))
            ctrl_wr[B_RUN] = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            per_q  <= '0;
            high_q <= '0;
        end else if (wr_en_i) begin
            if (sel_ctrl) ctrl_q <= ctrl_wr;
            if (sel_cnt) begin
                per_q  <= wr_data_i[F_PER_LSB +: CNT_W];
                high_q <= wr_data_i[F_HIGH_LSB +: CNT_W];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                if (sel_ctrl)     rd_data_o <= ctrl_q;
                else if (sel_cnt) rd_data_o <= count_word(per_q, high_q);
                else              rd_data_o <= '0;
            end
        end
    end

    assign run_o         = ctrl_q[B_RUN];
    assign hold_o        = ctrl_q[B_HOLD];
    assign prog_o.exp    = ctrl_exp(ctrl_q);
    assign prog_o.period = per_q;
    assign prog_o.high   = high_q;
    assign upd_o         = wr_en_i && (sel_ctrl || sel_cnt);

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_timer_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  upd_i,
    input  logic  hold_i,
    input  logic  busy_i,
    input  logic  boundary_i,
    input  tcfg_t prog_i,
    output tcfg_t act_o
);

    logic pending_q;
    logic prog_ok;
    logic load;

    assign prog_ok = (prog_i.period != '0) && (prog_i.high != '0);
    assign load    = pending_q && !hold_i && prog_ok && (!busy_i || boundary_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pending_q <= 1'b0;
            act_o     <= '0;
        end else begin
            pending_q <= upd_i || (pending_q && !load);
            if (load) act_o <= prog_i;
        end
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int EXP_W = 5,
    parameter int PRE_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    assign mask   = ~({PRE_W{1'b1}} << exp_i);
    assign tick_o = en_i && (cnt_q == mask);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) cnt_q <= '0;
        else if (tick_o)    cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o,
    output logic             pwm_o
);

    logic last;

    assign last       = (cnt_o == period_i - 1'b1);
    assign boundary_o = en_i && tick_i && last;
    assign pwm_o      = en_i && (cnt_o < high_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) cnt_o <= '0;
        else if (tick_i)    cnt_o <= last ? '0 : cnt_o + 1'b1;
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              rd_valid_o,
    output logic              pwm_o
);

    tcfg_t            prog_w;
    tcfg_t            act_w;
    logic             upd_w;
    logic             run_bit;
    logic             hold_bit;
    logic             run_d;
    logic             run_active;
    logic             tick_w;
    logic             bnd_w;
    logic [CNT_W-1:0] per_cnt_w;

    pwm_regs u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .run_o      (run_bit),
        .hold_o     (hold_bit),
        .prog_o     (prog_w),
        .upd_o      (upd_w)
    );

    // one cycle of start latency lets settings written with the enable land first
    always_ff @(posedge clk_i) begin
        if (rst_i) run_d <= 1'b0;
        else       run_d <= run_bit;
    end

    assign run_active = run_bit && run_d && (act_w.period != '0);

    pwm_shadow u_shadow (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .upd_i      (upd_w),
        .hold_i     (hold_bit),
        .busy_i     (run_active),
        .boundary_i (bnd_w),
        .prog_i     (prog_w),
        .act_o      (act_w)
    );

    pwm_prescaler #(.EXP_W(EXP_W), .PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (run_active),
        .exp_i  (act_w.exp),
        .tick_o (tick_w)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (run_active),
        .tick_i     (tick_w),
        .period_i   (act_w.period),
        .high_i     (act_w.high),
        .cnt_o      (per_cnt_w),
        .boundary_o (bnd_w),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             rd_en_i,
    input logic             rd_valid_o,
    input logic             pwm_o,
    input logic             run_bit,
    input logic             run_active,
    input logic             hold_bit,
    input logic [CNT_W-1:0] act_cyc,
    input logic [CNT_W-1:0] act_ph,
    input logic [EXP_W-1:0] act_exp,
    input logic [CNT_W-1:0] per_cnt,
    input logic [CNT_W-1:0] cyc_prog,
    input logic [CNT_W-1:0] ph_prog
);

    AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |=> rd_valid_o); // R2

    AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> !rd_valid_o); // R2

    AST_START_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_bit) |-> $past(cyc_prog != '0 && ph_prog != '0)); // R3

    AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        run_active |-> (per_cnt < act_cyc)); // R4

    AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_active && act_ph >= act_cyc) |-> pwm_o); // R6

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_bit |=> ($stable(act_cyc) && $stable(act_ph) && $stable(act_exp))); // R7

    AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_bit |=> (per_cnt == '0 && !pwm_o)); // R10

    AST_ACT_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        run_active |-> (act_ph != '0)); // R11

endmodule

bind pwm_timer pwm_timer_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rd_en_i    (rd_en_i),
    .rd_valid_o (rd_valid_o),
    .pwm_o      (pwm_o),
    .run_bit    (run_bit),
    .run_active (run_active),
    .hold_bit   (hold_bit),
    .act_cyc    (act_w.period),
    .act_ph     (act_w.high),
    .act_exp    (act_w.exp),
    .per_cnt    (per_cnt_w),
    .cyc_prog   (prog_w.period),
    .ph_prog    (prog_w.high)
);

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        pwm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic  val;
        string tag;
    } item_t;
    item_t wq[$];

    always #5 clk = ~clk;

    pwm_timer uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .pwm_o      (pwm)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: one queued item per cycle
    always @(negedge clk) begin
        item_t it;
        #1;
        if (wq.size() > 0) begin
            it = wq.pop_front();
            check(pwm === it.val, it.tag, "pwm", longint'(pwm), longint'(it.val));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check(rd_valid === 1'b1, tag, "rd_valid", longint'(rd_valid), 1);
        check(rd_data === exp, tag, "rd_data", longint'(rd_data), longint'(exp));
    endtask

    task automatic push_const(input logic v, input int k, input string tag);
        for (int i = 0; i < k; i++) wq.push_back('{v, tag});
    endtask

    task automatic push_wave(input int cyc, input int ph, input int n,
                             input int periods, input string tag);
        int len;
        int hi;
        len = cyc << n;
        hi  = ((ph < cyc) ? ph : cyc) << n;
        for (int p = 0; p < periods; p++)
            for (int i = 0; i < len; i++)
                wq.push_back('{logic'(i < hi), tag});
    endtask

    task automatic drain();
        while (wq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // returns at the negedge where the first high cycle of a period is visible
    task automatic wait_rise(input string tag);
        logic prev;
        bit   found;
        found = 1'b0;
        prev  = pwm;
        for (int k = 0; k < 400 && !found; k++) begin
            @(negedge clk);
            if (!prev && pwm) found = 1'b1;
            prev = pwm;
        end
        check(found, tag, "rising edge seen", longint'(found), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 check(pwm === 1'b0, "R1", "pwm after reset", longint'(pwm), 0);
        rd(4'h0, 32'h0, "R1 ctrl");
        rd(4'h4, 32'h0, "R1 count");
        rd(4'h8, 32'h0, "R1 unmapped");

        // R2 readback of every control bit and masked count fields
        wr(4'h0, 32'hA5A5_5A5A);
        rd(4'h0, 32'hA5A5_5A5A, "R2 ctrl");
        wr(4'h0, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, 32'h03FF_03FF, "R2 count");

        // R3 enable refused with zero high count
        wr(4'h4, 32'h0005_0000);
        wr(4'h0, 32'h0000_0011);
        push_const(1'b0, 8, "R3 idle");
        drain();
        rd(4'h0, 32'h0000_0010, "R3 run bit");

        // R4 / R9 basic waveform, settings loaded while idle
        wr(4'h4, 32'h0005_0002);
        wr(4'h0, 32'h0000_0001);
        push_const(1'b0, 1, "R4 start latency");
        push_wave(5, 2, 0, 2, "R4 R9 wave");
        drain();
        wr(4'h0, 32'h0);
        push_const(1'b0, 4, "R10 stop");
        drain();

        // R5 divider exponent 2*1+1 = 3
        wr(4'h4, 32'h0003_0001);
        wr(4'h0, 32'h0001_8001);
        push_const(1'b0, 1, "R5 start latency");
        push_wave(3, 1, 3, 2, "R5 wave");
        drain();
        wr(4'h0, 32'h0);
        drain();

        // R6 high count above period, R10 fresh restart
        wr(4'h4, 32'h0004_0007);
        wr(4'h0, 32'h0000_0001);
        push_const(1'b0, 1, "R10 restart latency");
        push_const(1'b1, 12, "R6 full high");
        drain();
        wr(4'h0, 32'h0);
        drain();

        // R7 hold freezes the running waveform
        wr(4'h4, 32'h0004_0001);
        wr(4'h0, 32'h0000_0001);
        push_const(1'b0, 1, "R4 start latency");
        push_wave(4, 1, 0, 1, "R4 wave");
        drain();
        wr(4'h0, 32'h0000_8801);
        wr(4'h4, 32'h0003_0002);
        rd(4'h4, 32'h0003_0002, "R7 count readback");
        rd(4'h0, 32'h0000_8801, "R7 ctrl readback");
        wait_rise("R7");
        push_wave(4, 1, 0, 2, "R7 old wave");
        drain();

        // R8 release hold away from a boundary; new settings at next boundary
        wait_rise("R8");
        wr(4'h0, 32'h0000_8001);
        wait_rise("R8");
        push_wave(3, 2, 1, 2, "R8 new wave");
        drain();

        // R11 zero period write while running is not applied
        wr(4'h4, 32'h0000_0004);
        rd(4'h4, 32'h0000_0004, "R11 count readback");
        wait_rise("R11");
        push_wave(3, 2, 1, 2, "R11 wave kept");
        drain();

        // R10 disable
        wr(4'h0, 32'h0);
        push_const(1'b0, 6, "R10 stop");
        drain();
        rd(4'h0, 32'h0, "R10 ctrl");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule